// File: doc/BRIEF.md
# Dual-Path Bus Port Controller

This block is the per-port control logic that sits between a 36-bit bidirectional data bus and two internal destinations: a FIFO queue and a one-word mailbox. Each transfer is qualified on the rising edge of the port clock by an active-low chip select and an active-high enable. A direction input chooses between a write, where the bus carries data into the block, and a read, where the block drives the bus. A mailbox-select input, sampled with each transfer, routes it either to the FIFO path or to the mailbox path.

On writes, FIFO-path data goes out as a write strobe plus data word, and only while the FIFO reports free space. Mailbox-path data is captured into the outgoing mailbox register and never reaches the FIFO. On reads, the block puts on the bus either the incoming mailbox word (mailbox select high) or the FIFO output register (mailbox select low). A FIFO-path read raises a read-advance strobe only while the FIFO reports data. The pad's tri-state output enable is driven straight from chip select and direction, so the bus is released the moment chip select goes high. The FIFO storage and the mailbox status flags are outside this block.

Top module: `bport_ctrl`

## Requirements
- R1: A transfer happens only on a rising edge where cs_n=0 and en=1. With cs_n=1 or en=0, fifo_wr_en and fifo_rd_en stay 0 and mbx_out_data keeps its value.
- R2: data_oe is 1 exactly when cs_n=0 and rd_nwr=1 (1 = read, 0 = write). It follows these inputs without waiting for a clock edge and does not depend on en.
- R3: While data_oe is 0, data_out is all zeros.
- R4: While data_oe is 1, data_out equals mbx_in_data when mbx_sel=1 and fifo_rd_data when mbx_sel=0.
- R5: A transfer with rd_nwr=0 and mbx_sel=1 loads data_in into mbx_out_data at that edge and leaves fifo_wr_en at 0.
- R6: A transfer with rd_nwr=0 and mbx_sel=0 raises fifo_wr_en, with fifo_wr_data equal to data_in, only while fifo_full_n=1. When fifo_full_n=0, the write is dropped.
- R7: A transfer with rd_nwr=1 and mbx_sel=0 raises fifo_rd_en only while fifo_empty_n=1. A mailbox read (mbx_sel=1) never raises fifo_rd_en.
- R8: rst_n=0 clears mbx_out_data at once and blocks all transfers. After rst_n rises, the first two rising edges perform no transfer, and the third edge is the first that can.
- R9: mbx_out_data changes only through R5 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Transfer enable |
| rd_nwr | input | 1 | 1 = read (block drives bus), 0 = write |
| mbx_sel | input | 1 | 1 = mailbox path, 0 = FIFO path |
| data_in | input | 36 | Bus value seen by the block (from pad) |
| data_out | output | 36 | Value the block drives to the pad |
| data_oe | output | 1 | Pad tri-state output enable |
| fifo_full_n | input | 1 | 1 = FIFO can accept a word |
| fifo_empty_n | input | 1 | 1 = FIFO output register holds data |
| fifo_rd_data | input | 36 | FIFO output register |
| fifo_wr_en | output | 1 | FIFO write strobe for this edge |
| fifo_wr_data | output | 36 | Word written to the FIFO |
| fifo_rd_en | output | 1 | FIFO read-advance strobe for this edge |
| mbx_in_data | input | 36 | Incoming mailbox register (from the other port) |
| mbx_out_data | output | 36 | Outgoing mailbox register |

## Verification
A wrong path decode appears at the ports in the same cycle. It shows up as a FIFO strobe where none should be, a strobe missing, or the wrong source on data_out, so every combination of select, enable, direction, path and FIFO flags is swept with a distinct data word. A mailbox register that loads when it should not, or misses a load, only shows on mbx_out_data one edge later. The bench therefore checks that register after every edge against its own running model. This catches a stray capture during reads, idle cycles or the reset-release window. It also catches a mailbox reset that fails to act asynchronously.

// File: rtl/bport_pkg.sv
package bport_pkg;
  parameter int unsigned BPORT_WIDTH = 36;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_FIFO_WR = 3'd1,
    ACC_MBX_WR  = 3'd2,
    ACC_FIFO_RD = 3'd3,
    ACC_MBX_RD  = 3'd4
  } acc_e;
endpackage

// File: rtl/bport_rst_sync.sv
module bport_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[LAST-1:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ok = chain_q[LAST];
endmodule

// File: rtl/bport_decode.sv
module bport_decode
  import bport_pkg::*;
(
  input  logic active,
  input  logic cs_n,
  input  logic en,
  input  logic rd_nwr,
  input  logic mbx_sel,
  output acc_e acc,
  output logic drive
);
  logic sel_ok;

  always_comb begin
    sel_ok = active && !cs_n && en;
    drive  = !cs_n && rd_nwr;
    acc    = ACC_NONE;
    if (sel_ok) begin
      case ({rd_nwr, mbx_sel})
        2'b00:   acc = ACC_FIFO_WR;
        2'b01:   acc = ACC_MBX_WR;
        2'b10:   acc = ACC_FIFO_RD;
        default: acc = ACC_MBX_RD;
      endcase
    end
  end
endmodule

// File: rtl/bport_mbx_reg.sv
module bport_mbx_reg #(
  parameter int unsigned W = 36
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;

  always_comb begin
    q_next = q;
    if (load) q_next = d;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) q <= '0;
    else         q <= q_next;
  end
endmodule

// File: rtl/bport_rd_mux.sv
module bport_rd_mux #(
  parameter int unsigned W = 36
) (
  input  logic         drive,
  input  logic         pick_mbx,
  input  logic [W-1:0] mbx_word,
  input  logic [W-1:0] fifo_word,
  output logic [W-1:0] bus_word
);
  always_comb begin
    bus_word = '0;
    if (drive) bus_word = pick_mbx ? mbx_word : fifo_word;
  end
endmodule

// File: rtl/bport_ctrl.sv
module bport_ctrl
  import bport_pkg::*;
#(
  parameter int unsigned W          = BPORT_WIDTH,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         en,
  input  logic         rd_nwr,
  input  logic         mbx_sel,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_out,
  output logic         data_oe,
  input  logic         fifo_full_n,
  input  logic         fifo_empty_n,
  input  logic [W-1:0] fifo_rd_data,
  output logic         fifo_wr_en,
  output logic [W-1:0] fifo_wr_data,
  output logic         fifo_rd_en,
  input  logic [W-1:0] mbx_in_data,
  output logic [W-1:0] mbx_out_data
);
  logic rst_ok;
  acc_e acc;
  logic drive;
  logic mbx_load;

  bport_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  bport_decode u_dec (
    .active  (rst_ok),
    .cs_n    (cs_n),
    .en      (en),
    .rd_nwr  (rd_nwr),
    .mbx_sel (mbx_sel),
    .acc     (acc),
    .drive   (drive)
  );

  always_comb begin
    mbx_load     = (acc == ACC_MBX_WR);
    fifo_wr_en   = (acc == ACC_FIFO_WR) && fifo_full_n;
    fifo_rd_en   = (acc == ACC_FIFO_RD) && fifo_empty_n;
    fifo_wr_data = data_in;
    data_oe      = drive;
  end

  bport_mbx_reg #(.W(W)) u_mbx (
    .clk    (clk),
    .rst_ok (rst_ok),
    .load   (mbx_load),
    .d      (data_in),
    .q      (mbx_out_data)
  );

  bport_rd_mux #(.W(W)) u_mux (
    .drive     (drive),
    .pick_mbx  (mbx_sel),
    .mbx_word  (mbx_in_data),
    .fifo_word (fifo_rd_data),
    .bus_word  (data_out)
  );
endmodule

// File: rtl/bport_ctrl_chk.sv
module bport_ctrl_chk #(
  parameter int unsigned W = 36
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         cs_n,
  input logic         en,
  input logic         rd_nwr,
  input logic         mbx_sel,
  input logic [W-1:0] data_in,
  input logic [W-1:0] data_out,
  input logic         data_oe,
  input logic         fifo_full_n,
  input logic         fifo_empty_n,
  input logic         fifo_wr_en,
  input logic         fifo_rd_en,
  input logic [W-1:0] mbx_out_data
);
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_ok)
    (cs_n || !en) |-> (!fifo_wr_en && !fifo_rd_en)); // R1
  AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_ok)
    cs_n |-> !data_oe); // R2
  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_ok)
    !data_oe |-> (data_out == '0)); // R3
  AST_MBX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_ok)
    (!cs_n && en && !rd_nwr && mbx_sel) |=> (mbx_out_data == $past(data_in))); // R5
  AST_MBX_NO_FIFO: assert property (@(posedge clk) disable iff (!rst_ok)
    mbx_sel |-> (!fifo_wr_en && !fifo_rd_en)); // R7
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ok)
    !fifo_full_n |-> !fifo_wr_en); // R6
  AST_EMPTY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_ok)
    !fifo_empty_n |-> !fifo_rd_en); // R7
  AST_MBX_HOLD: assert property (@(posedge clk) disable iff (!rst_ok)
    !(!cs_n && en && !rd_nwr && mbx_sel) |=> $stable(mbx_out_data)); // R9
endmodule

bind bport_ctrl bport_ctrl_chk #(.W(W)) u_chk (
  .clk          (clk),
  .rst_ok       (rst_ok),
  .cs_n         (cs_n),
  .en           (en),
  .rd_nwr       (rd_nwr),
  .mbx_sel      (mbx_sel),
  .data_in      (data_in),
  .data_out     (data_out),
  .data_oe      (data_oe),
  .fifo_full_n  (fifo_full_n),
  .fifo_empty_n (fifo_empty_n),
  .fifo_wr_en   (fifo_wr_en),
  .fifo_rd_en   (fifo_rd_en),
  .mbx_out_data (mbx_out_data)
);

// File: tb/sim_bport_ctrl.sv
`timescale 1ns/1ps
module sim_bport_ctrl;
  localparam int W = 36;

  logic         clk = 1'b0;
  logic         rst_n, cs_n, en, rd_nwr, mbx_sel, fifo_full_n, fifo_empty_n;
  logic [W-1:0] data_in, fifo_rd_data, mbx_in_data;
  logic [W-1:0] data_out, fifo_wr_data, mbx_out_data;
  logic         data_oe, fifo_wr_en, fifo_rd_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_mbx;

  always #2.5 clk = ~clk;

  bport_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .en(en), .rd_nwr(rd_nwr),
    .mbx_sel(mbx_sel), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .fifo_full_n(fifo_full_n), .fifo_empty_n(fifo_empty_n),
    .fifo_rd_data(fifo_rd_data), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .fifo_rd_en(fifo_rd_en),
    .mbx_in_data(mbx_in_data), .mbx_out_data(mbx_out_data)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; en = 1'b0; rd_nwr = 1'b0; mbx_sel = 1'b0;
    fifo_full_n = 1'b1; fifo_empty_n = 1'b1;
    data_in = '0; fifo_rd_data = 36'h0_F1F0_0001; mbx_in_data = 36'hA_BCDE_0002;
    exp_mbx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R8 reset mbx", mbx_out_data, '0);
    check("R2 reset oe", {35'd0, data_oe}, '0);
    check("R3 reset bus", data_out, '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // Sweep every control combination with distinct data words
    for (int rep = 0; rep < 4; rep++) begin
      for (int c = 0; c < 64; c++) begin
        logic a_cs_n, a_en, a_rd, a_mbx, a_full_n, a_empty_n, act, exp_oe;
        logic [W-1:0] exp_out;
        @(negedge clk);
        a_cs_n = c[0]; a_en = c[1]; a_rd = c[2]; a_mbx = c[3];
        a_full_n = c[4]; a_empty_n = c[5];
        cs_n = a_cs_n; en = a_en; rd_nwr = a_rd; mbx_sel = a_mbx;
        fifo_full_n = a_full_n; fifo_empty_n = a_empty_n;
        data_in      = W'((c + 1) * 36'h9_E377_9B1 + rep * 36'h1_0101_0101) ^ 36'h5_A5A5_A5A5;
        fifo_rd_data = W'((c + 7) * 36'h3_1415_927 + rep);
        mbx_in_data  = ~W'((c + 3) * 36'h2_7182_818 + rep);
        #1;
        act    = !a_cs_n && a_en;
        exp_oe = !a_cs_n && a_rd;
        exp_out = exp_oe ? (a_mbx ? mbx_in_data : fifo_rd_data) : '0;
        check("R2 oe", {35'd0, data_oe}, {35'd0, exp_oe});
        if (exp_oe) check("R4 read source", data_out, exp_out);
        else        check("R3 quiet bus", data_out, '0);
        check("R6 R1 wr strobe", {35'd0, fifo_wr_en},
              {35'd0, act && !a_rd && !a_mbx && a_full_n});
        check("R7 R1 rd strobe", {35'd0, fifo_rd_en},
              {35'd0, act && a_rd && !a_mbx && a_empty_n});
        if (act && !a_rd && !a_mbx) check("R6 wr data", fifo_wr_data, data_in);
        if (act && !a_rd && a_mbx) exp_mbx = data_in;
        @(posedge clk); #1;
        check("R5 R9 mailbox", mbx_out_data, exp_mbx);
      end
    end

    // Asynchronous reset in mid-run, then the release window
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R8 async clear", mbx_out_data, '0);
    exp_mbx = '0;
    cs_n = 1'b0; en = 1'b1; rd_nwr = 1'b0; mbx_sel = 1'b1; data_in = 36'hC_0FFE_E123;
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 edge1 blocked", mbx_out_data, '0);
    mbx_sel = 1'b0;
    #0.5;
    check("R8 edge1 no wr", {35'd0, fifo_wr_en}, '0);
    mbx_sel = 1'b1;
    @(posedge clk); #1;
    check("R8 edge2 blocked", mbx_out_data, '0);
    @(posedge clk); #1;
    check("R8 edge3 loads", mbx_out_data, 36'hC_0FFE_E123);
    cs_n = 1'b1;
    @(posedge clk); #1;
    check("R1 deselect hold", mbx_out_data, 36'hC_0FFE_E123);
    finish_run();
  end
endmodule